// File: doc/BRIEF.md
# Refresh-Distance Restore Timing Selector

This block sits in a DRAM memory controller beside the command scheduler. The controller issues an activate, read or write to a row group. The block then works out how many cycles remain before that group's next refresh, and from that it picks a restore timing pair (tRAS, tWR) that is no longer than the cell needs. A cell that will be refreshed again soon only has to hold its charge until then. It can therefore be restored to a lower voltage, which takes less time than a full restore.

A refresh interval is split into four equal sub-windows, each with its own programmable timing pair. A fifth pair, for full restore, is used whenever the distance to the next refresh is a full nominal period or more. Each group can run at the nominal refresh period or at a low rate that is a multiple of it. In selective upgrade mode, an access to a low-rate group moves that group's pending refresh onto the nominal schedule, so that a shorter restore can be used. After that refresh the group returns to its low rate. The refresh engine learns which groups are due from a due flag per group, and it reports each refresh it issues back to the block.

Time is counted in clock cycles. `SUBWIN` is the length of one sub-window. The nominal period `FAST` is `4*SUBWIN` and the low-rate period `SLOW` is `FAST*SLOW_MULT`. With the default parameters these are 64 and 128 cycles.

Top module: `restore_timing_sel`

## Requirements
- R1: After reset every group is at the nominal rate with a distance of `FAST`, no due flag is set and `out_vld` is low. The tRAS defaults are 32, 28, 24 and 20 for sub-windows 0 to 3, and 35 for full restore. The tWR defaults are 14, 12, 10 and 8 for sub-windows 0 to 3, and 15 for full restore.
- R2: `out_vld` is high in exactly the cycle after a cycle with `acc_vld` high. The `out_win`, `out_tras` and `out_twr` values it carries belong to that access.
- R3: For an access at distance d < `FAST`, the sub-window code is 0 for d ≥ 3·SUBWIN, 1 for d ≥ 2·SUBWIN, 2 for d ≥ SUBWIN and 3 otherwise. The timing pair output is the one stored for that code. With defaults, d = 40 gives code 1.
- R4: An access at distance d ≥ `FAST` gets code 4 and the full-restore timing pair.
- R5: A configuration write stores `cfg_data` as tRAS (`cfg_sel`=0) or tWR (`cfg_sel`=1) for entry `cfg_idx`, where 0 to 3 select sub-windows and 4 selects full restore. Accesses see the new value from the next cycle on.
- R6: Each group's distance drops by one every cycle and saturates at 0. `ref_due[g]` is high while group g's distance is 0 and stays high until that group is refreshed. An access at distance 0 gets code 3.
- R7: A pulse on `ref_vld` reloads the distance of group `ref_grp`: to `SLOW` if the group is at the low rate, otherwise to `FAST`. Its due flag clears.
- R8: When upgrade mode is off, a low-rate group uses the same four-window division of the last `FAST` cycles. Any access farther from its refresh gets full restore.
- R9: When `upg_mode` is high, an access to a low-rate group that is not yet upgraded marks it upgraded. If its distance exceeds `SLOW-FAST`, the distance is first reduced by `SLOW-FAST`, and the access uses the reduced distance. The next refresh clears the mark and reloads `SLOW`.
- R10: A rate change written through `rate_we` leaves the running distance untouched. It takes effect at the group's next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access request strobe |
| acc_grp | input | GW | Row group of the access |
| upg_mode | input | 1 | Selective upgrade enable |
| ref_vld | input | 1 | Refresh issued pulse |
| ref_grp | input | GW | Group that was refreshed |
| rate_we | input | 1 | Refresh rate write strobe |
| rate_grp | input | GW | Group whose rate is written |
| rate_low | input | 1 | 1 = low rate, 0 = nominal rate |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 1 | 0 = tRAS, 1 = tWR |
| cfg_idx | input | 3 | Entry: 0..3 sub-window, 4 full restore |
| cfg_data | input | TW | Timing value to store |
| out_vld | output | 1 | Timing result valid |
| out_win | output | 3 | Chosen code, 0..3 or 4 for full |
| out_tras | output | TW | Selected tRAS |
| out_twr | output | TW | Selected tWR |
| ref_due | output | NGRP | Per-group refresh-due flags |

## Verification
The classification is tried at distances on both sides of every sub-window boundary, and at zero after saturation. These cases separate an off-by-one in the comparisons from a wrong window order. Low-rate groups are accessed at distances above and below one nominal period, with upgrade mode off and then on. This shows whether the full-restore cutoff, the distance subtraction of the upgrade and the return to the slow reload each work on their own. Programmed timing values that differ from the defaults show that the output reads the stored entries rather than fixed values. A rate change in the middle of a period shows that the new rate takes effect only at the next refresh.

// File: rtl/restore_timing_sel.sv
module restore_timing_sel #(
  parameter int NGRP      = 8,
  parameter int SUBWIN    = 16,
  parameter int SLOW_MULT = 2,
  parameter int TW        = 8,
  parameter int FULL_TRAS = 35,
  parameter int FULL_TWR  = 15,
  parameter int GW        = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_vld,
  input  logic [GW-1:0]   acc_grp,
  input  logic            upg_mode,
  input  logic            ref_vld,
  input  logic [GW-1:0]   ref_grp,
  input  logic            rate_we,
  input  logic [GW-1:0]   rate_grp,
  input  logic            rate_low,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [2:0]      cfg_idx,
  input  logic [TW-1:0]   cfg_data,
  output logic            out_vld,
  output logic [2:0]      out_win,
  output logic [TW-1:0]   out_tras,
  output logic [TW-1:0]   out_twr,
  output logic [NGRP-1:0] ref_due
);
  localparam int FAST = 4 * SUBWIN;
  localparam int SLOW = FAST * SLOW_MULT;
  localparam int CW   = $clog2(SLOW + 1);
  localparam logic [CW-1:0] FAST_C = CW'(FAST);
  localparam logic [CW-1:0] SLOW_C = CW'(SLOW);
  localparam logic [CW-1:0] GAP_C  = CW'(SLOW - FAST);
  localparam logic [CW-1:0] S1_C   = CW'(SUBWIN);
  localparam logic [CW-1:0] S2_C   = CW'(2 * SUBWIN);
  localparam logic [CW-1:0] S3_C   = CW'(3 * SUBWIN);

  logic [NGRP*CW-1:0] rem_flat;
  logic [NGRP-1:0]    low_v, upg_v;
  logic [CW-1:0]      rem_a, eff;
  logic               do_upg;
  logic [2:0]         win;
  logic [TW-1:0]      tras [5];
  logic [TW-1:0]      twr  [5];

  assign rem_a  = rem_flat[acc_grp*CW +: CW];
  assign do_upg = upg_mode && low_v[acc_grp] && !upg_v[acc_grp];
  assign eff    = (do_upg && rem_a > GAP_C) ? rem_a - GAP_C : rem_a;
  assign win    = (eff >= FAST_C) ? 3'd4 :
                  (eff >= S3_C)   ? 3'd0 :
                  (eff >= S2_C)   ? 3'd1 :
                  (eff >= S1_C)   ? 3'd2 : 3'd3;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    logic [CW-1:0] rem_q, base;
    logic          low_q, upg_q, hit_ref, hit_acc;

    assign hit_ref = ref_vld && ref_grp == GW'(g);
    assign hit_acc = acc_vld && do_upg && acc_grp == GW'(g);
    assign base    = hit_acc ? eff : rem_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rem_q <= FAST_C;
        low_q <= 1'b0;
        upg_q <= 1'b0;
      end else begin
        if (rate_we && rate_grp == GW'(g)) low_q <= rate_low;
        if (hit_ref) begin
          rem_q <= low_q ? SLOW_C : FAST_C;
          upg_q <= 1'b0;
        end else begin
          rem_q <= (base == '0) ? '0 : base - 1'b1;
          if (hit_acc) upg_q <= 1'b1;
        end
      end
    end

    assign rem_flat[g*CW +: CW] = rem_q;
    assign low_v[g]             = low_q;
    assign upg_v[g]             = upg_q;
    assign ref_due[g]           = (rem_q == '0);

    // R6
    due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_due[g] && !hit_ref |=> ref_due[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        tras[i] <= TW'(FULL_TRAS - 3 - 4 * i);
        twr[i]  <= TW'(FULL_TWR - 1 - 2 * i);
      end
      tras[4] <= TW'(FULL_TRAS);
      twr[4]  <= TW'(FULL_TWR);
    end else if (cfg_we && cfg_idx <= 3'd4) begin
      if (cfg_sel) twr[cfg_idx]  <= cfg_data;
      else         tras[cfg_idx] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_win  <= 3'd0;
      out_tras <= '0;
      out_twr  <= '0;
    end else begin
      out_vld <= acc_vld;
      if (acc_vld) begin
        out_win  <= win;
        out_tras <= tras[win];
        out_twr  <= twr[win];
      end
    end
  end

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> out_vld);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> !out_vld);
  // R7
  reload_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |=> !ref_due[$past(ref_grp)]);
  // R9
  upg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |=> !upg_v[$past(ref_grp)]);
  // R3
  near_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld && !upg_mode && rem_a < FAST_C |=> out_win != 3'd4);
endmodule

// File: tb/sim_restore_timing_sel.sv
module sim_restore_timing_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_vld = 1'b0, upg_mode = 1'b0, ref_vld = 1'b0;
  logic       rate_we = 1'b0, rate_low = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [2:0] acc_grp = '0, ref_grp = '0, rate_grp = '0, cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic       out_vld;
  logic [2:0] out_win;
  logic [7:0] out_tras, out_twr;
  logic [7:0] ref_due;

  int n_tests = 0, n_fail = 0;
  int e_tras [5] = '{32, 28, 24, 20, 35};
  int e_twr  [5] = '{14, 12, 10, 8, 15};

  always #5 clk = ~clk;

  restore_timing_sel u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_grp(acc_grp),
    .upg_mode(upg_mode), .ref_vld(ref_vld), .ref_grp(ref_grp),
    .rate_we(rate_we), .rate_grp(rate_grp), .rate_low(rate_low),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .out_vld(out_vld), .out_win(out_win), .out_tras(out_tras),
    .out_twr(out_twr), .ref_due(ref_due));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_win(input int d);
    if (d >= 64) return 4;
    if (d >= 48) return 0;
    if (d >= 32) return 1;
    if (d >= 16) return 2;
    return 3;
  endfunction

  task automatic do_ref(input int g);
    ref_vld = 1'b1; ref_grp = 3'(g);
    @(negedge clk);
    ref_vld = 1'b0;
  endtask

  task automatic set_rate(input int g, input bit v);
    rate_we = 1'b1; rate_grp = 3'(g); rate_low = v;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic write_cfg(input bit sel, input int idx, input int val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 3'(idx); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access_check(input int g, input int d, input string tag);
    int w;
    acc_vld = 1'b1; acc_grp = 3'(g);
    @(negedge clk);
    acc_vld = 1'b0;
    w = exp_win(d);
    chk(out_vld == 1'b1, {tag, " R2 valid"}, int'(out_vld), 1);
    chk(int'(out_win) == w, {tag, " code"}, int'(out_win), w);
    chk(int'(out_tras) == e_tras[w], {tag, " tRAS"}, int'(out_tras), e_tras[w]);
    chk(int'(out_twr) == e_twr[w], {tag, " tWR"}, int'(out_twr), e_twr[w]);
  endtask

  task automatic t_reset;
    chk(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
    chk(ref_due == 8'h00, "R1 due flags after reset", int'(ref_due), 0);
    access_check(0, 64, "R1 R4 first access full");
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk(out_vld == 1'b0, "R2 no access no valid", int'(out_vld), 0);
  endtask

  task automatic t_windows;
    int dl [10] = '{63, 48, 47, 40, 32, 31, 16, 15, 1, 0};
    foreach (dl[i]) begin
      do_ref(1);
      chk(ref_due[1] == 1'b0, "R7 due clear after refresh", int'(ref_due[1]), 0);
      repeat (64 - dl[i]) @(negedge clk);
      if (dl[i] == 0) chk(ref_due[1] == 1'b1, "R6 due at zero", int'(ref_due[1]), 1);
      access_check(1, dl[i], "R3 window");
    end
    do_ref(1);
    repeat (70) @(negedge clk);
    chk(ref_due[1] == 1'b1, "R6 due held when saturated", int'(ref_due[1]), 1);
    access_check(1, 0, "R6 saturated distance");
  endtask

  task automatic t_cfg;
    write_cfg(1'b0, 2, 77); e_tras[2] = 77;
    write_cfg(1'b1, 2, 5);  e_twr[2] = 5;
    do_ref(2);
    repeat (44) @(negedge clk);
    access_check(2, 20, "R5 programmed window");
    write_cfg(1'b0, 4, 50); e_tras[4] = 50;
    do_ref(2);
    access_check(2, 64, "R5 R4 programmed full");
  endtask

  task automatic t_slow;
    set_rate(3, 1'b1);
    do_ref(3);
    repeat (24) @(negedge clk);
    access_check(3, 104, "R8 low rate far");
    repeat (63) @(negedge clk);
    access_check(3, 40, "R8 low rate near");
  endtask

  task automatic t_upgrade;
    upg_mode = 1'b1;
    do_ref(3);
    repeat (24) @(negedge clk);
    access_check(3, 40, "R9 upgrade shortens");
    repeat (8) @(negedge clk);
    access_check(3, 31, "R9 upgraded schedule");
    upg_mode = 1'b0;
    do_ref(3);
    repeat (28) @(negedge clk);
    access_check(3, 100, "R9 back to low rate");
  endtask

  task automatic t_rate;
    do_ref(5);
    set_rate(5, 1'b1);
    repeat (43) @(negedge clk);
    access_check(5, 20, "R10 rate change deferred");
    do_ref(5);
    repeat (28) @(negedge clk);
    access_check(5, 100, "R10 new rate after refresh");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_windows();
    t_cfg();
    t_slow();
    t_upgrade();
    t_rate();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule